// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync and a data-enable strobe, and it reports the coordinate of the pixel being shown. A pixel tick comes either straight from the input clock or from an integer divider on that clock. Every line runs through four phases in a fixed order: sync pulse, back porch, active pixels, front porch. Every frame runs through the same four phases, counted in lines.

Software supplies each porch, sync width and active size as the wanted count minus one. Two enables start and stop the raster. `video_en` acts at once. `video_en_f` is sampled only at a frame boundary, so a request to stop lets the current frame complete. A frame interrupt can be set at the start of any of the four vertical phases. Its pending flag stays set until software writes a one to `irq_clr`.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts (hsw+1)+(hbp+1)+(pix+1)+(hfp+1) pixel ticks. Sync is asserted for the first hsw+1 ticks, followed by hbp+1 ticks of back porch, pix+1 ticks of active data, then hfp+1 ticks of front porch.
- R2: A frame uses the same phase order counted in lines. Vertical sync is asserted for the first vsw+1 lines and the first active line is line vsw+vbp+2.
- R3: A frame lasts exactly the line length multiplied by (vsw+1)+(vbp+1)+(lin+1)+(vfp+1) pixel ticks.
- R4: With `cfg_div_sel`=1 there is one pixel tick every `cfg_div`+1 input clocks. With `cfg_div_sel`=0 there is one tick per clock and `cfg_div` has no effect.
- R5: `de` is high only when both the line and the frame are in their active phase. While it is high, `pix_x` counts 0..pix and `pix_y` counts 0..lin. Both coordinates read 0 when `de` is low.
- R6: `cfg_sync_inv`=1 inverts both sync outputs. Sync is active-high when it is 0, and both syncs sit at the inactive level while the raster is stopped.
- R7: When `video_en` is 0 the raster stops in the same cycle: `de` goes low, both syncs go inactive and the counters reset. Setting it back to 1 restarts the raster at the first clock of sync on line 0.
- R8: `video_en_f` is sampled at the last tick of a frame, or in any cycle where the raster is stopped. Clearing it mid-frame lets the rest of that frame run and then halts the raster.
- R9: `irq_src` selects the cycle in which the pending flag sets: 0 = start of vertical sync, 1 = start of vertical back porch, 2 = start of the first active line, 3 = start of vertical front porch. The flag becomes visible on the clock edge where the line counter enters that phase.
- R10: The pending flag sets only when both `irq_global_en` and `irq_frame_en` are 1. `irq` equals pending AND both enables.
- R11: The pending flag holds until a cycle in which `irq_clr` is 1 clears it. A new event in that same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | source clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_hsw | input | HW | hsync width minus one |
| cfg_hbp | input | HW | horizontal back porch minus one |
| cfg_pix | input | HW | active width minus one |
| cfg_hfp | input | HW | horizontal front porch minus one |
| cfg_vsw | input | VW | vsync width in lines minus one |
| cfg_vbp | input | VW | vertical back porch minus one |
| cfg_lin | input | VW | active height minus one |
| cfg_vfp | input | VW | vertical front porch minus one |
| cfg_div | input | DIVW | division ratio minus one |
| cfg_div_sel | input | 1 | 1 = use divider, 0 = 1:1 |
| cfg_sync_inv | input | 1 | invert both sync outputs |
| video_en | input | 1 | immediate run enable |
| video_en_f | input | 1 | run enable applied at frame boundary |
| irq_global_en | input | 1 | global interrupt enable |
| irq_frame_en | input | 1 | frame interrupt enable |
| irq_src | input | 2 | frame interrupt trigger phase |
| irq_clr | input | 1 | write-one-to-clear for pending |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | data enable |
| pix_x | output | HW | active pixel column |
| pix_y | output | VW | active line row |
| irq_pending | output | 1 | frame interrupt pending flag |
| irq | output | 1 | frame interrupt request |

## Verification
The bench instantiates HW=8, VW=8 and DIVW=4, and programs a 15-clock line and an 8-line frame. At this size one frame takes 120 clocks, or 360 clocks with a divide ratio of three. Each test can therefore cover several complete frames and compare every phase width, the frame period and all four interrupt trigger points against small counts worked out by hand. The short frame also lets the deferred stop be seen in full: the remainder of the frame, the boundary where the raster halts, and the silence that follows.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW   = 10,
  parameter int VW   = 10,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HW-1:0]   cfg_hsw,
  input  logic [HW-1:0]   cfg_hbp,
  input  logic [HW-1:0]   cfg_pix,
  input  logic [HW-1:0]   cfg_hfp,
  input  logic [VW-1:0]   cfg_vsw,
  input  logic [VW-1:0]   cfg_vbp,
  input  logic [VW-1:0]   cfg_lin,
  input  logic [VW-1:0]   cfg_vfp,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_div_sel,
  input  logic            cfg_sync_inv,
  input  logic            video_en,
  input  logic            video_en_f,
  input  logic            irq_global_en,
  input  logic            irq_frame_en,
  input  logic [1:0]      irq_src,
  input  logic            irq_clr,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [HW-1:0]   pix_x,
  output logic [VW-1:0]   pix_y,
  output logic            irq_pending,
  output logic            irq
);
  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;

  logic [DIVW-1:0] div_cnt;
  logic [HCW-1:0]  hcnt;
  logic [VCW-1:0]  vcnt;
  logic            run_f;
  logic            pend;

  logic [HCW-1:0] h_bp0, h_act0, h_fp0, h_last;
  logic [VCW-1:0] v_bp0, v_act0, v_fp0, v_last, v_next, v_evt;

  assign h_bp0  = HCW'(cfg_hsw) + HCW'(1);
  assign h_act0 = h_bp0 + HCW'(cfg_hbp) + HCW'(1);
  assign h_fp0  = h_act0 + HCW'(cfg_pix) + HCW'(1);
  assign h_last = h_fp0 + HCW'(cfg_hfp);

  assign v_bp0  = VCW'(cfg_vsw) + VCW'(1);
  assign v_act0 = v_bp0 + VCW'(cfg_vbp) + VCW'(1);
  assign v_fp0  = v_act0 + VCW'(cfg_lin) + VCW'(1);
  assign v_last = v_fp0 + VCW'(cfg_vfp);

  wire run  = video_en & run_f;
  wire tick = run & (~cfg_div_sel | (div_cnt == cfg_div));
  wire eol  = tick & (hcnt == h_last);
  wire eof  = eol & (vcnt == v_last);

  assign v_next = (vcnt == v_last) ? '0 : vcnt + VCW'(1);

  always_comb begin
    case (irq_src)
      2'd0:    v_evt = '0;
      2'd1:    v_evt = v_bp0;
      2'd2:    v_evt = v_act0;
      default: v_evt = v_fp0;
    endcase
  end

  wire evt = eol & (v_next == v_evt) & irq_global_en & irq_frame_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
      run_f   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (!run) begin
        div_cnt <= '0;
        hcnt    <= '0;
        vcnt    <= '0;
      end else begin
        div_cnt <= tick ? '0 : div_cnt + DIVW'(1);
        if (tick) hcnt <= eol ? '0 : hcnt + HCW'(1);
        if (eol)  vcnt <= v_next;
      end
      if (!run || eof) run_f <= video_en_f;
      pend <= evt | (pend & ~irq_clr);
    end
  end

  wire h_act = (hcnt >= h_act0) && (hcnt < h_fp0);
  wire v_act = (vcnt >= v_act0) && (vcnt < v_fp0);

  assign hsync       = (run & (hcnt < h_bp0)) ^ cfg_sync_inv;
  assign vsync       = (run & (vcnt < v_bp0)) ^ cfg_sync_inv;
  assign de          = run & h_act & v_act;
  assign pix_x       = de ? HW'(hcnt - h_act0) : '0;
  assign pix_y       = de ? VW'(vcnt - v_act0) : '0;
  assign irq_pending = pend;
  assign irq         = pend & irq_global_en & irq_frame_en;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] cfg_pix,
  input logic [VW-1:0] cfg_lin,
  input logic          cfg_sync_inv,
  input logic          video_en,
  input logic          irq_global_en,
  input logic          irq_frame_en,
  input logic          irq_clr,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [HW-1:0] pix_x,
  input logic [VW-1:0] pix_y,
  input logic          irq_pending,
  input logic          irq
);
  p_no_sync_in_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == cfg_sync_inv) && (vsync == cfg_sync_inv));

  p_blank_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> !de && pix_x == '0 && pix_y == '0);

  p_coord_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> pix_x <= cfg_pix && pix_y <= cfg_lin);

  p_row_starts_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> pix_x == '0);

  p_set_needs_enables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(irq_global_en && irq_frame_en));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_pending && irq_global_en && irq_frame_en);

  p_clear_only_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pending) |-> $past(irq_clr));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pix(cfg_pix), .cfg_lin(cfg_lin),
  .cfg_sync_inv(cfg_sync_inv), .video_en(video_en),
  .irq_global_en(irq_global_en), .irq_frame_en(irq_frame_en),
  .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync), .de(de),
  .pix_x(pix_x), .pix_y(pix_y), .irq_pending(irq_pending), .irq(irq)
);

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
  localparam int HW = 8, VW = 8, DIVW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] cfg_hsw, cfg_hbp, cfg_pix, cfg_hfp;
  logic [VW-1:0] cfg_vsw, cfg_vbp, cfg_lin, cfg_vfp;
  logic [DIVW-1:0] cfg_div;
  logic cfg_div_sel, cfg_sync_inv, video_en, video_en_f;
  logic irq_global_en, irq_frame_en, irq_clr;
  logic [1:0] irq_src;
  logic hsync, vsync, de, irq_pending, irq;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int tests = 0, failed = 0;

  always #5 clk = ~clk;

  lcd_timing_gen #(.HW(HW), .VW(VW), .DIVW(DIVW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_pix(cfg_pix), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_lin(cfg_lin), .cfg_vfp(cfg_vfp),
    .cfg_div(cfg_div), .cfg_div_sel(cfg_div_sel), .cfg_sync_inv(cfg_sync_inv),
    .video_en(video_en), .video_en_f(video_en_f),
    .irq_global_en(irq_global_en), .irq_frame_en(irq_frame_en),
    .irq_src(irq_src), .irq_clr(irq_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .irq_pending(irq_pending), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_vs_rise();
    logic prev;
    prev = vsync ^ cfg_sync_inv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((vsync ^ cfg_sync_inv) && !prev) return;
      prev = vsync ^ cfg_sync_inv;
    end
    check(0, "vsync timeout", 0, 1);
  endtask

  task automatic frame_period(output int n);
    wait_vs_rise();
    n = 0;
    begin : lp
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        n++;
        if ((vsync ^ cfg_sync_inv) && n > 0) begin
          if (!(uut.vsync ^ cfg_sync_inv)) ;
        end
        if (n > 1 && (vsync ^ cfg_sync_inv)) begin
          int k;
          k = n;
        end
      end
    end
  endtask

  // frame period between two rising edges of vsync
  task automatic measure_period(output int n);
    logic prev;
    wait_vs_rise();
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if ((vsync ^ cfg_sync_inv) && !prev) return;
      prev = vsync ^ cfg_sync_inv;
    end
    n = -1;
  endtask

  task automatic t_reset();
    check(hsync == 0 && vsync == 0, "R7 reset syncs", {hsync, vsync}, 0);
    check(de == 0 && pix_x == 0 && pix_y == 0, "R5 reset de/coords", de, 0);
    check(irq_pending == 0 && irq == 0, "R11 reset pending", irq_pending, 0);
  endtask

  task automatic t_line_frame();
    int hs_hi = 0, vs_hi = 0, de_cnt = 0, max_x = 0, max_y = 0, idle_bad = 0;
    int since_hs = 0, since_def = 99, first_de = -1, rise_bad = 0, fp_bad = 0, rises = 0;
    logic p_hs = 0, p_de = 0;
    int per;
    wait_vs_rise();
    for (int i = 0; i < 120; i++) begin
      if (hsync && !p_hs) begin
        if (since_def != 99 && since_def != 2) fp_bad++;
        since_hs = 0;
        since_def = 99;
      end else since_hs++;
      if (p_de && !de) since_def = 1;
      else if (since_def != 99) since_def++;
      if (de && !p_de) begin
        rises++;
        if (since_hs != 5) rise_bad++;
        if (first_de < 0) first_de = i;
      end
      if (hsync) hs_hi++;
      if (vsync) vs_hi++;
      if (de) begin
        de_cnt++;
        if (int'(pix_x) > max_x) max_x = int'(pix_x);
        if (int'(pix_y) > max_y) max_y = int'(pix_y);
      end else if (pix_x != 0 || pix_y != 0) idle_bad++;
      p_hs = hsync;
      p_de = de;
      @(negedge clk);
    end
    check(hs_hi == 16, "R1 hsync clocks per frame", hs_hi, 16);
    check(rise_bad == 0 && rises == 4, "R1 hsync-to-de distance", rise_bad, 0);
    check(fp_bad == 0, "R1 front porch length", fp_bad, 0);
    check(vs_hi == 15, "R2 vsync clocks", vs_hi, 15);
    check(first_de == 50, "R2 first active clock", first_de, 50);
    check(de_cnt == 32, "R5 de clocks", de_cnt, 32);
    check(max_x == 7 && max_y == 3, "R5 max coordinates", max_x * 100 + max_y, 703);
    check(idle_bad == 0, "R5 coords zero outside de", idle_bad, 0);
    measure_period(per);
    check(per == 120, "R3 frame period", per, 120);
  endtask

  task automatic t_divider();
    int per;
    cfg_div = 4'd2; cfg_div_sel = 1'b1;
    measure_period(per);
    measure_period(per);
    check(per == 360, "R4 divide by three", per, 360);
    cfg_div_sel = 1'b0;
    measure_period(per);
    measure_period(per);
    check(per == 120, "R4 bypass ignores divider", per, 120);
    cfg_div = 4'd0; cfg_div_sel = 1'b1;
    measure_period(per);
    measure_period(per);
    check(per == 120, "R4 ratio one", per, 120);
    cfg_div_sel = 1'b0;
  endtask

  task automatic t_invert();
    int hs_lo = 0, vs_lo = 0;
    cfg_sync_inv = 1'b1;
    wait_vs_rise();
    for (int i = 0; i < 120; i++) begin
      if (!hsync) hs_lo++;
      if (!vsync) vs_lo++;
      @(negedge clk);
    end
    check(hs_lo == 16 && vs_lo == 15, "R6 inverted sync widths", hs_lo * 1000 + vs_lo, 16015);
    video_en = 1'b0;
    @(negedge clk);
    check(hsync == 1 && vsync == 1, "R6 idle level inverted", {hsync, vsync}, 3);
    video_en = 1'b1;
    cfg_sync_inv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stop();
    int bad = 0;
    cyc(70);
    video_en = 1'b0;
    @(negedge clk);
    check(de == 0 && hsync == 0 && vsync == 0 && pix_x == 0, "R7 immediate stop", {de, hsync, vsync}, 0);
    for (int i = 0; i < 50; i++) begin
      if (de || hsync || vsync) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 stays stopped", bad, 0);
    video_en = 1'b1;
    @(negedge clk);
    check(hsync == 1 && vsync == 1 && de == 0, "R7 restart at line 0 sync", {hsync, vsync, de}, 6);
  endtask

  task automatic t_defer();
    int de_cnt = 0, bad = 0;
    wait_vs_rise();
    cyc(30);
    video_en_f = 1'b0;
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      if (de) de_cnt++;
    end
    check(de_cnt == 32, "R8 current frame completes", de_cnt, 32);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (de || vsync || hsync) bad++;
    end
    check(bad == 0, "R8 halted after frame end", bad, 0);
    video_en_f = 1'b1;
    cyc(2);
    check(vsync == 1, "R8 restart when stopped", vsync, 1);
  endtask

  task automatic t_irq_src();
    int exp_d[4] = '{120, 15, 45, 105};
    for (int s = 0; s < 4; s++) begin
      int n;
      irq_src = 2'(s);
      irq_global_en = 1'b1; irq_frame_en = 1'b1;
      wait_vs_rise();
      wait_vs_rise();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      n = 1;
      while (!irq_pending && n < 1000) begin
        @(negedge clk);
        n++;
      end
      check(n == exp_d[s], $sformatf("R9 trigger delay src %0d", s), n, exp_d[s]);
    end
  endtask

  task automatic t_irq_gate();
    int bad = 0;
    irq_src = 2'd0;
    irq_global_en = 1'b0; irq_frame_en = 1'b1;
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (irq_pending || irq) bad++;
    end
    check(bad == 0, "R10 global enable gates set", bad, 0);
    irq_global_en = 1'b1;
    wait_vs_rise();
    check(irq_pending == 1 && irq == 1, "R10 set with both enables", {irq_pending, irq}, 3);
    irq_frame_en = 1'b0;
    @(negedge clk);
    check(irq == 0 && irq_pending == 1, "R10 irq masked, pending kept", {irq_pending, irq}, 2);
    cyc(250);
    check(irq_pending == 1, "R11 pending sticky", irq_pending, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq_pending == 0, "R11 write-one clears", irq_pending, 0);
    bad = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (irq_pending) bad++;
    end
    check(bad == 0, "R10 frame enable gates set", bad, 0);
  endtask

  initial begin
    cfg_hsw = 8'd1; cfg_hbp = 8'd2; cfg_pix = 8'd7; cfg_hfp = 8'd1;
    cfg_vsw = 8'd0; cfg_vbp = 8'd1; cfg_lin = 8'd3; cfg_vfp = 8'd0;
    cfg_div = 4'd2; cfg_div_sel = 1'b0; cfg_sync_inv = 1'b0;
    video_en = 1'b0; video_en_f = 1'b0;
    irq_global_en = 1'b0; irq_frame_en = 1'b0; irq_src = 2'd0; irq_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    video_en = 1'b1; video_en_f = 1'b1;
    @(negedge clk);
    t_line_frame();
    t_divider();
    t_invert();
    t_stop();
    t_defer();
    t_irq_src();
    t_irq_gate();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #1500000;
    tests++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule